// File: doc/BRIEF.md
# Parallel Port Register Interface

This block is the host-facing register file of a PC-style parallel printer port working in standard and bidirectional modes. A host issues byte accesses into an eight-byte window. The block decodes that window into a data byte, a status view, a control byte, and two plain holding registers for an enhanced-port address and data byte. It drives data and control bytes toward the printer-side pins and samples the data and status pins coming back.

A data write latches the byte and pulses a strobe toward the pin side in the same cycle. A control write is widened so that its two top bits are always one. It reaches the control pins, with a one-cycle change strobe, only when the widened value differs from the stored one. When bidirectional mode is on, a data read returns the byte on the external data pins, not the last written byte. An acknowledge event from the printer side raises the interrupt line only while the acknowledge interrupt is enabled. A host read of status drops it again.

The host interface applies no back-pressure. Every access with `host_valid` high is taken in that cycle. An accepted read answers with a one-cycle `host_rvalid` pulse and `host_rdata` in the following cycle. A rejected access (wrong size) gets no response and changes nothing.

Top module: `lpt_regfile`

## Requirements
- R1: After reset the data byte and both enhanced-port registers read 0x00, the control pins show 0xC0, the interrupt is low and neither pin strobe is active.
- R2: Only address bits 2:0 select a register (0 data, 1 status, 2 control, 3 enhanced address, 4 enhanced data); higher address bits are ignored.
- R3: An accepted write to offset 0 raises `pin_data_stb` for exactly that cycle with `pin_data_out` equal to the written byte, and the byte stays on `pin_data_out` afterwards.
- R4: A control write stores the written byte with bits 7 and 6 forced to one; control reads and `pin_control_out` return that value.
- R5: `pin_ctrl_stb` is high for one cycle, the cycle after the write, only when the forced value differs from the stored one; an equal write changes nothing on the control pins and gives no strobe.
- R6: With control bit 5 clear, a read of offset 0 returns the last data byte. With bit 5 set, it returns `pin_data_in` sampled at the accepting edge and stores that byte as the data register.
- R7: A read of offset 1 returns `pin_status_in` sampled at the accepting edge and clears the interrupt.
- R8: An `ack_event` pulse sets the interrupt only while control bit 4 is one. An acknowledge in the same cycle as a status read leaves the interrupt set.
- R9: Writes to offsets 1, 5, 6 and 7 change no register and give no strobe; reads of offsets 5, 6 and 7 return 0xFF.
- R10: An access whose `host_size` is not 2'b00 (one byte; 2'b01 is two bytes, 2'b10 four) is rejected: no register changes, no strobe, no read response.
- R11: Each accepted read gives exactly one `host_rvalid` pulse, in the cycle after acceptance, carrying the read value on `host_rdata`.
- R12: Offsets 3 and 4 hold the last byte written to each and return it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request, taken in its cycle |
| host_write | input | 1 | 1 write, 0 read |
| host_addr | input | ADDR_W | Access address, bits 2:0 decoded |
| host_size | input | 2 | Access size, 2'b00 one byte |
| host_wdata | input | 8 | Write byte |
| host_rvalid | output | 1 | Read response valid, one cycle |
| host_rdata | output | 8 | Read response byte |
| pin_data_out | output | 8 | Data byte toward the printer side |
| pin_data_stb | output | 1 | Data write strobe, same cycle as the write |
| pin_control_out | output | 8 | Control byte toward the printer side |
| pin_ctrl_stb | output | 1 | Control change strobe |
| pin_data_in | input | 8 | Data pins sampled in bidirectional mode |
| pin_status_in | input | 8 | Status pins: 7 busy, 6 ack, 5 paper out, 4 select, 3 error, 2 interrupt, 0 timeout |
| ack_event | input | 1 | Acknowledge event pulse |
| irq | output | 1 | Interrupt line |

## Verification
The control path is tried with a write equal to the reset value, a changing write, and a repeat of that same value. Together these tell a change detector apart from a plain write strobe and show the forcing of the top bits. Data reads are compared with bidirectional mode off and on, with the pin byte chosen to differ from the written byte. A later read in the other mode then shows the register was overwritten by the sampled byte. Acknowledge pulses are sent with the enable set, with it clear, and in the same cycle as a status read, which separates gating from clear priority. Aliased addresses, dead offsets and wrong-size accesses are each followed by readbacks and pin checks, so any stray update becomes visible.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W   = 8;
  localparam int OFS_W    = 3;
  localparam int NUM_OFS  = 1 << OFS_W;

  localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_EADDR = 3'd3;
  localparam logic [OFS_W-1:0] OFS_EDATA = 3'd4;

  localparam logic [1:0] SIZE_BYTE = 2'b00;

  localparam int CTRL_BIDIR_BIT  = 5;
  localparam int CTRL_ACKIRQ_BIT = 4;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] DEAD_FILL  = 8'hFF;

  typedef struct packed {
    logic               rd;
    logic               wr;
    logic [NUM_OFS-1:0] sel;
  } acc_t;
endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output acc_t              acc
);
  logic ok;
  logic unused_hi;

  assign ok        = valid && (size == SIZE_BYTE);
  assign acc.rd    = ok && !write;
  assign acc.wr    = ok && write;
  assign unused_hi = ^addr[ADDR_W-1:OFS_W];

  for (genvar i = 0; i < NUM_OFS; i++) begin : g_sel
    assign acc.sel[i] = ok && (addr[OFS_W-1:0] == OFS_W'(i));
  end
endmodule

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              chg_stb
);
  logic [BYTE_W-1:0] forced;
  logic              differs;

  assign forced  = wdata | CTRL_FORCE;
  assign differs = (forced != ctrl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_FORCE;
      chg_stb <= 1'b0;
    end else begin
      chg_stb <= wr_en && differs;
      if (wr_en && differs) ctrl_q <= forced;
    end
  end
endmodule

// File: rtl/lpt_irq.sv
module lpt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_event,
  input  logic ack_en,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (ack_event && ack_en) irq <= 1'b1;
    else if (clr)               irq <= 1'b0;
  end
endmodule

// File: rtl/lpt_regfile.sv
module lpt_regfile
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [7:0]        host_wdata,
  output logic              host_rvalid,
  output logic [7:0]        host_rdata,
  output logic [7:0]        pin_data_out,
  output logic              pin_data_stb,
  output logic [7:0]        pin_control_out,
  output logic              pin_ctrl_stb,
  input  logic [7:0]        pin_data_in,
  input  logic [7:0]        pin_status_in,
  input  logic              ack_event,
  output logic              irq
);
  acc_t              acc;
  logic [BYTE_W-1:0] data_q, eaddr_q, edata_q, ctrl_q;
  logic [BYTE_W-1:0] rd_val;
  logic              bidir;

  lpt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid (host_valid),
    .write (host_write),
    .addr  (host_addr),
    .size  (host_size),
    .acc   (acc)
  );

  lpt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc.wr && acc.sel[OFS_CTRL]),
    .wdata   (host_wdata),
    .ctrl_q  (ctrl_q),
    .chg_stb (pin_ctrl_stb)
  );

  lpt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_event (ack_event),
    .ack_en    (ctrl_q[CTRL_ACKIRQ_BIT]),
    .clr       (acc.rd && acc.sel[OFS_STAT]),
    .irq       (irq)
  );

  assign bidir           = ctrl_q[CTRL_BIDIR_BIT];
  assign pin_control_out = ctrl_q;
  assign pin_data_stb    = acc.wr && acc.sel[OFS_DATA];
  assign pin_data_out    = pin_data_stb ? host_wdata : data_q;

  always_comb begin
    rd_val = DEAD_FILL;
    unique case (host_addr[OFS_W-1:0])
      OFS_DATA:  rd_val = bidir ? pin_data_in : data_q;
      OFS_STAT:  rd_val = pin_status_in;
      OFS_CTRL:  rd_val = ctrl_q;
      OFS_EADDR: rd_val = eaddr_q;
      OFS_EDATA: rd_val = edata_q;
      default:   rd_val = DEAD_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q      <= '0;
      eaddr_q     <= '0;
      edata_q     <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= acc.rd;
      if (acc.rd) host_rdata <= rd_val;
      if (acc.wr && acc.sel[OFS_DATA])  data_q  <= host_wdata;
      if (acc.rd && acc.sel[OFS_DATA] && bidir) data_q <= pin_data_in;
      if (acc.wr && acc.sel[OFS_EADDR]) eaddr_q <= host_wdata;
      if (acc.wr && acc.sel[OFS_EDATA]) edata_q <= host_wdata;
    end
  end
endmodule

// File: rtl/lpt_regfile_sva.sv
module lpt_regfile_sva #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_write,
  input logic [ADDR_W-1:0] host_addr,
  input logic [1:0]        host_size,
  input logic              host_rvalid,
  input logic [7:0]        pin_control_out,
  input logic              pin_ctrl_stb,
  input logic              ack_event,
  input logic              irq
);
  p_ctrl_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_control_out[7:6] == 2'b11);

  p_ctrl_stb_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ctrl_stb |-> (pin_control_out != $past(pin_control_out)));

  p_ctrl_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ctrl_stb |-> $stable(pin_control_out));

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write && host_size == 2'b00 &&
     host_addr[2:0] == 3'd1 && !ack_event) |=> !irq);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_event && pin_control_out[4]));

  p_size_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_size != 2'b00) |=> (!host_rvalid && !pin_ctrl_stb));

  p_rvalid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_valid && !host_write && host_size == 2'b00));
endmodule

bind lpt_regfile lpt_regfile_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_valid      (host_valid),
  .host_write      (host_write),
  .host_addr       (host_addr),
  .host_size       (host_size),
  .host_rvalid     (host_rvalid),
  .pin_control_out (pin_control_out),
  .pin_ctrl_stb    (pin_ctrl_stb),
  .ack_event       (ack_event),
  .irq             (irq)
);

// File: tb/lpt_regfile_tb.sv
module lpt_regfile_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_valid = 1'b0, host_write = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [1:0]        host_size = 2'b00;
  logic [7:0]        host_wdata = '0;
  logic              host_rvalid, pin_data_stb, pin_ctrl_stb, irq;
  logic [7:0]        host_rdata, pin_data_out, pin_control_out;
  logic [7:0]        pin_data_in = '0, pin_status_in = '0;
  logic              ack_event = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lpt_regfile #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [7:0] d,
                    output logic dstb, output logic [7:0] dout);
    @(negedge clk);
    host_valid = 1; host_write = 1; host_addr = a; host_size = sz; host_wdata = d;
    #1; dstb = pin_data_stb; dout = pin_data_out;
    @(negedge clk);
    host_valid = 0; host_write = 0; host_size = 2'b00;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic ack,
                    output logic rv, output logic [7:0] v);
    @(negedge clk);
    host_valid = 1; host_write = 0; host_addr = a; host_size = sz; ack_event = ack;
    @(negedge clk);
    host_valid = 0; host_size = 2'b00; ack_event = 0;
    #1; rv = host_rvalid; v = host_rdata;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    logic rv; logic [7:0] v;
    rd(a, 2'b00, 1'b0, rv, v);
    chk(rv === 1'b1, "R11 rvalid", {7'd0, rv}, 8'h01);
    chk(v === exp, req, v, exp);
  endtask

  task automatic ctrl_wr(input logic [7:0] d, input logic [7:0] exp_out, input logic exp_stb, input string req);
    logic s; logic [7:0] o;
    wr(16'h0002, 2'b00, d, s, o);
    chk(pin_ctrl_stb === exp_stb, {req, " ctrl strobe"}, {7'd0, pin_ctrl_stb}, {7'd0, exp_stb});
    chk(pin_control_out === exp_out, {req, " ctrl pins"}, pin_control_out, exp_out);
  endtask

  task automatic ack_pulse(input logic exp_irq, input string req);
    @(negedge clk); ack_event = 1;
    @(negedge clk); ack_event = 0;
    #1; chk(irq === exp_irq, req, {7'd0, irq}, {7'd0, exp_irq});
  endtask

  task automatic t_reset;
    chk(pin_control_out === 8'hC0, "R1 ctrl reset", pin_control_out, 8'hC0);
    chk(pin_data_out === 8'h00, "R1 data reset", pin_data_out, 8'h00);
    chk(irq === 1'b0, "R1 irq reset", {7'd0, irq}, 8'h00);
    chk(!pin_data_stb && !pin_ctrl_stb, "R1 strobes idle", {6'd0, pin_data_stb, pin_ctrl_stb}, 8'h00);
    rd_chk(16'h0003, 8'h00, "R1 enhanced address reset");
    rd_chk(16'h0004, 8'h00, "R1 enhanced data reset");
    rd_chk(16'h0000, 8'h00, "R1 data read reset");
  endtask

  task automatic t_data_write;
    logic s; logic [7:0] o;
    wr(16'h0000, 2'b00, 8'h5A, s, o);
    chk(s === 1'b1, "R3 data strobe in write cycle", {7'd0, s}, 8'h01);
    chk(o === 8'h5A, "R3 data pins in write cycle", o, 8'h5A);
    #1; chk(pin_data_stb === 1'b0, "R3 strobe one cycle", {7'd0, pin_data_stb}, 8'h00);
    chk(pin_data_out === 8'h5A, "R3 data pins hold", pin_data_out, 8'h5A);
    rd_chk(16'h0000, 8'h5A, "R6 data read, bidir off");
  endtask

  task automatic t_ctrl;
    ctrl_wr(8'h00, 8'hC0, 1'b0, "R5 equal to reset value");
    ctrl_wr(8'h15, 8'hD5, 1'b1, "R4 forced top bits");
    ctrl_wr(8'h15, 8'hD5, 1'b0, "R5 repeat write");
    ctrl_wr(8'hD5, 8'hD5, 1'b0, "R5 forced equal");
    rd_chk(16'h0002, 8'hD5, "R4 control readback");
  endtask

  task automatic t_epp_alias;
    logic s; logic [7:0] o;
    wr(16'h003B, 2'b00, 8'hA7, s, o);
    rd_chk(16'h0003, 8'hA7, "R2 alias write to offset 3");
    wr(16'h0004, 2'b00, 8'h3C, s, o);
    rd_chk(16'h100C, 8'h3C, "R12 offset 4 via aliased read");
    rd_chk(16'h0102, 8'hD5, "R2 aliased control read");
  endtask

  task automatic t_ignored;
    logic s; logic [7:0] o;
    logic [2:0] dead [4] = '{3'd1, 3'd5, 3'd6, 3'd7};
    for (int i = 0; i < 4; i++) begin
      wr({13'd0, dead[i]}, 2'b00, 8'h11, s, o);
      chk(s === 1'b0 && pin_ctrl_stb === 1'b0, "R9 dead write strobes", {6'd0, s, pin_ctrl_stb}, 8'h00);
    end
    chk(pin_control_out === 8'hD5, "R9 control untouched", pin_control_out, 8'hD5);
    rd_chk(16'h0000, 8'h5A, "R9 data untouched");
    rd_chk(16'h0003, 8'hA7, "R9 enhanced address untouched");
    rd_chk(16'h0004, 8'h3C, "R9 enhanced data untouched");
    for (int i = 5; i < 8; i++) rd_chk(ADDR_W'(i), 8'hFF, "R9 dead offset read");
  endtask

  task automatic t_bidir;
    ctrl_wr(8'h35, 8'hF5, 1'b1, "R6 enable bidir");
    pin_data_in = 8'h96;
    rd_chk(16'h0000, 8'h96, "R6 bidir read samples pins");
    pin_data_in = 8'h00;
    ctrl_wr(8'h15, 8'hD5, 1'b1, "R6 disable bidir");
    rd_chk(16'h0000, 8'h96, "R6 sampled byte stored");
    chk(pin_data_out === 8'h96, "R6 stored byte on data pins", pin_data_out, 8'h96);
  endtask

  task automatic t_irq;
    logic rv; logic [7:0] v;
    ack_pulse(1'b1, "R8 ack sets irq when enabled");
    pin_status_in = 8'h78;
    rd(16'h0001, 2'b00, 1'b0, rv, v);
    chk(rv === 1'b1 && v === 8'h78, "R7 status value", v, 8'h78);
    chk(irq === 1'b0, "R7 status read clears irq", {7'd0, irq}, 8'h00);
    ctrl_wr(8'h05, 8'hC5, 1'b1, "R8 disable ack irq");
    ack_pulse(1'b0, "R8 ack ignored when disabled");
    ctrl_wr(8'h15, 8'hD5, 1'b1, "R8 enable ack irq");
    ack_pulse(1'b1, "R8 ack sets irq again");
    rd(16'h0001, 2'b00, 1'b1, rv, v);
    chk(irq === 1'b1, "R8 ack beats same-cycle status clear", {7'd0, irq}, 8'h01);
    rd(16'h0009, 2'b00, 1'b0, rv, v);
    chk(irq === 1'b0, "R7 aliased status read clears", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_size;
    logic s, rv; logic [7:0] o, v;
    wr(16'h0000, 2'b01, 8'hEE, s, o);
    chk(s === 1'b0, "R10 wide data write no strobe", {7'd0, s}, 8'h00);
    rd_chk(16'h0000, 8'h96, "R10 data unchanged");
    wr(16'h0002, 2'b10, 8'h3F, s, o);
    chk(pin_ctrl_stb === 1'b0, "R10 wide control write no strobe", {7'd0, pin_ctrl_stb}, 8'h00);
    chk(pin_control_out === 8'hD5, "R10 control unchanged", pin_control_out, 8'hD5);
    wr(16'h0003, 2'b01, 8'h00, s, o);
    rd(16'h0003, 2'b01, 1'b0, rv, v);
    chk(rv === 1'b0, "R10 wide read no response", {7'd0, rv}, 8'h00);
    rd_chk(16'h0003, 8'hA7, "R10 enhanced address unchanged");
    @(negedge clk); #1;
    chk(host_rvalid === 1'b0, "R11 single response pulse", {7'd0, host_rvalid}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_data_write();
    t_ctrl();
    t_epp_alias();
    t_ignored();
    t_bidir();
    t_irq();
    t_size();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule